// File: doc/BRIEF.md
# Two-Client In-Order Memory Request Scheduler

This block lets two requesters, a line cache and a stream prefetcher, share a single memory port that answers reads strictly in the order they were issued. Each requester has its own request channel and its own response channel. Requests first land in a small queue for that requester. An arbiter then moves them onto the memory port, one per cycle at most.

Every read that goes out leaves behind a small receipt in a tracking queue. The receipt holds the requester's identity and the tag it supplied. For the prefetcher, that tag names the stream that asked for the line. Because memory answers in order, the oldest receipt always describes the response now on the bus, so memory returns no identifier of its own. Writes leave no receipt and produce no response. The depth of the receipt queue caps how many reads can be in flight.

A returning response is presented only to the requester its receipt names. If that requester is not ready, the response waits on the memory side. The block is placed between a cache and its memory controller. Several prefetch streams can each have line reads in flight through it at once.

Top module: `req_sched_top`

## Requirements
- R1: Requests from one client appear on the memory port in the order that client handed them over, with address and write flag unchanged.
- R2: Whenever both client queues hold a request at an issue opportunity, grants alternate between the clients. Once a request is presented, the port holds that choice. The cache gets the first grant after reset.
- R3: Reads in flight (issued, not yet answered) never exceed RCPT_DEPTH. A read at the head of the choice is not presented while RCPT_DEPTH reads are outstanding, and that limit is reachable.
- R4: A write (memReqWrite=1) is never answered on either client response channel.
- R5: Each memory response goes to exactly one client, the one that issued the matching read. It carries that read's tag and the memory data, and each client sees its reads answered in its own issue order.
- R6: While the addressed client holds its response-ready low, memRspReady stays low and the client's response valid, tag and data stay unchanged.
- R7: A client's request ready is low exactly while its queue holds Q_DEPTH accepted-but-unissued requests.
- R8: After reset, no memory request and no client response is valid, and both clients' request ready are high.
- R9: Once memReqValid is high while memReqReady is low, memReqValid stays high the next cycle with the same address and write flag.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Asynchronous reset, active low |
| cacheReqValid | input | 1 | Cache request present |
| cacheReqReady | output | 1 | Cache queue can accept |
| cacheReqWrite | input | 1 | Cache request is a write |
| cacheReqAddr | input | ADDR_W | Cache request address |
| cacheReqTag | input | TAG_W | Cache tag echoed on the response |
| cacheRspValid | output | 1 | Response for the cache present |
| cacheRspReady | input | 1 | Cache takes the response |
| cacheRspData | output | DATA_W | Response data |
| cacheRspTag | output | TAG_W | Tag of the answered cache read |
| pfReqValid | input | 1 | Prefetcher request present |
| pfReqReady | output | 1 | Prefetcher queue can accept |
| pfReqWrite | input | 1 | Prefetcher request is a write |
| pfReqAddr | input | ADDR_W | Prefetcher request address |
| pfReqTag | input | TAG_W | Stream identifier echoed on the response |
| pfRspValid | output | 1 | Response for the prefetcher present |
| pfRspReady | input | 1 | Prefetcher takes the response |
| pfRspData | output | DATA_W | Response data |
| pfRspTag | output | TAG_W | Stream identifier of the answered read |
| memReqValid | output | 1 | Request on the memory port |
| memReqReady | input | 1 | Memory accepts the request |
| memReqWrite | output | 1 | Memory request is a write |
| memReqAddr | output | ADDR_W | Memory request address |
| memRspValid | input | 1 | Memory read response present |
| memRspReady | output | 1 | Scheduler takes the memory response |
| memRspData | input | DATA_W | Memory read data |

## Verification
The properties assume the memory returns one response per issued read, strictly in issue order. They also assume it never answers a write, and that it keeps memRspValid and memRspData steady until memRspReady is seen. The bench memory keeps a FIFO of issued read addresses with a fixed 100-cycle latency. It raises a response only for the oldest entry and holds it until it is taken. That keeps every run within those assumptions, while the memory's request-ready and both clients' response-ready are swept through several stall patterns.

// File: rtl/req_sched_pkg.sv
package req_sched_pkg;

  localparam logic CLI_CACHE = 1'b0;
  localparam logic CLI_PF    = 1'b1;

  // control -> datapath
  typedef struct packed {
    logic issueSel;   // client whose queue head feeds the memory port
    logic popCache;
    logic popPf;
    logic pushRcpt;
    logic popRcpt;
  } strobe_t;

  // datapath -> control
  typedef struct packed {
    logic cacheAvail;
    logic pfAvail;
    logic cacheHeadWr;
    logic pfHeadWr;
    logic rcptFull;
    logic rcptAvail;
    logic rcptHeadCli;
  } status_t;

endpackage

// File: rtl/req_sched_fifo.sv
module req_sched_fifo #(
  parameter int WIDTH = 8,
  parameter int DEPTH = 4
) (
  input  logic             clk,
  input  logic             rstN,
  input  logic             push,
  input  logic [WIDTH-1:0] pushData,
  input  logic             pop,
  output logic             full,
  output logic             avail,
  output logic [WIDTH-1:0] head
);
  localparam int PTR_W = (DEPTH > 1) ? $clog2(DEPTH) : 1;
  localparam int CNT_W = $clog2(DEPTH + 1);

  logic [WIDTH-1:0] store [DEPTH];
  logic [PTR_W-1:0] rdPtr, wrPtr;
  logic [CNT_W-1:0] count;

  function automatic logic [PTR_W-1:0] bump(input logic [PTR_W-1:0] p);
    return (p == PTR_W'(DEPTH - 1)) ? '0 : p + 1'b1;
  endfunction

  always_ff @(posedge clk) begin
    if (push) store[wrPtr] <= pushData;
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      rdPtr <= '0;
      wrPtr <= '0;
      count <= '0;
    end else begin
      if (push) wrPtr <= bump(wrPtr);
      if (pop)  rdPtr <= bump(rdPtr);
      count <= count + CNT_W'(push) - CNT_W'(pop);
    end
  end

  assign full  = (count == CNT_W'(DEPTH));
  assign avail = (count != '0);
  assign head  = store[rdPtr];
endmodule

// File: rtl/req_sched_dpath.sv
module req_sched_dpath
  import req_sched_pkg::*;
#(
  parameter int ADDR_W     = 16,
  parameter int TAG_W      = 4,
  parameter int Q_DEPTH    = 4,
  parameter int RCPT_DEPTH = 8,
  localparam int ENTRY_W   = 1 + TAG_W + ADDR_W
) (
  input  logic                    clk,
  input  logic                    rstN,
  input  logic [1:0]              reqValid,
  output logic [1:0]              reqReady,
  input  logic [1:0][ENTRY_W-1:0] reqEntry,
  input  strobe_t                 strobe,
  output status_t                 status,
  input  logic                    memRspValid,
  output logic                    memReqWrite,
  output logic [ADDR_W-1:0]       memReqAddr,
  output logic [1:0]              rspValid,
  output logic [TAG_W-1:0]        rspTag
);
  localparam int RCPT_W = 1 + TAG_W;

  logic [1:0]              qFull, qAvail, qPop;
  logic [1:0][ENTRY_W-1:0] qHead;
  logic [ENTRY_W-1:0]      selEntry;
  logic [RCPT_W-1:0]       rcptHead;
  logic                    rcptFull, rcptAvail;

  assign qPop = {strobe.popPf, strobe.popCache};

  for (genvar g = 0; g < 2; g++) begin : gQueue
    req_sched_fifo #(.WIDTH(ENTRY_W), .DEPTH(Q_DEPTH)) queue_i (
      .clk      (clk),
      .rstN     (rstN),
      .push     (reqValid[g] && !qFull[g]),
      .pushData (reqEntry[g]),
      .pop      (qPop[g]),
      .full     (qFull[g]),
      .avail    (qAvail[g]),
      .head     (qHead[g])
    );
    assign reqReady[g] = !qFull[g];
  end

  // entry layout: {write, tag, addr}
  assign selEntry    = qHead[strobe.issueSel];
  assign memReqWrite = selEntry[ENTRY_W-1];
  assign memReqAddr  = selEntry[ADDR_W-1:0];

  req_sched_fifo #(.WIDTH(RCPT_W), .DEPTH(RCPT_DEPTH)) rcpt_i (
    .clk      (clk),
    .rstN     (rstN),
    .push     (strobe.pushRcpt),
    .pushData ({strobe.issueSel, selEntry[ADDR_W +: TAG_W]}),
    .pop      (strobe.popRcpt),
    .full     (rcptFull),
    .avail    (rcptAvail),
    .head     (rcptHead)
  );

  assign rspTag = rcptHead[TAG_W-1:0];

  for (genvar g = 0; g < 2; g++) begin : gRoute
    assign rspValid[g] = memRspValid && rcptAvail && (rcptHead[RCPT_W-1] == 1'(g));
  end

  always_comb begin
    status.cacheAvail  = qAvail[0];
    status.pfAvail     = qAvail[1];
    status.cacheHeadWr = qHead[0][ENTRY_W-1];
    status.pfHeadWr    = qHead[1][ENTRY_W-1];
    status.rcptFull    = rcptFull;
    status.rcptAvail   = rcptAvail;
    status.rcptHeadCli = rcptHead[RCPT_W-1];
  end
endmodule

// File: rtl/req_sched_ctrl.sv
module req_sched_ctrl
  import req_sched_pkg::*;
(
  input  logic       clk,
  input  logic       rstN,
  input  status_t    status,
  input  logic       memReqReady,
  input  logic       memRspValid,
  input  logic [1:0] rspReady,
  output strobe_t    strobe,
  output logic       memReqValid,
  output logic       memRspReady
);
  logic lastGrant, holdValid, holdSel;
  logic sel, selAvail, selWr, fire;

  always_comb begin
    if (holdValid)                               sel = holdSel;
    else if (status.cacheAvail && status.pfAvail) sel = ~lastGrant;
    else if (status.cacheAvail)                  sel = CLI_CACHE;
    else                                         sel = CLI_PF;
  end

  assign selAvail    = (sel == CLI_PF) ? status.pfAvail  : status.cacheAvail;
  assign selWr       = (sel == CLI_PF) ? status.pfHeadWr : status.cacheHeadWr;
  assign memReqValid = selAvail && (selWr || !status.rcptFull);
  assign fire        = memReqValid && memReqReady;

  assign memRspReady = status.rcptAvail && rspReady[status.rcptHeadCli];

  always_comb begin
    strobe.issueSel = sel;
    strobe.popCache = fire && (sel == CLI_CACHE);
    strobe.popPf    = fire && (sel == CLI_PF);
    strobe.pushRcpt = fire && !selWr;
    strobe.popRcpt  = memRspValid && memRspReady;
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      lastGrant <= CLI_PF;
      holdValid <= 1'b0;
      holdSel   <= CLI_CACHE;
    end else begin
      holdValid <= memReqValid && !memReqReady;
      holdSel   <= sel;
      if (fire) lastGrant <= sel;
    end
  end
endmodule

// File: rtl/req_sched_top.sv
module req_sched_top
  import req_sched_pkg::*;
#(
  parameter int ADDR_W     = 16,
  parameter int DATA_W     = 32,
  parameter int TAG_W      = 4,
  parameter int Q_DEPTH    = 4,
  parameter int RCPT_DEPTH = 8
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              cacheReqValid,
  output logic              cacheReqReady,
  input  logic              cacheReqWrite,
  input  logic [ADDR_W-1:0] cacheReqAddr,
  input  logic [TAG_W-1:0]  cacheReqTag,
  output logic              cacheRspValid,
  input  logic              cacheRspReady,
  output logic [DATA_W-1:0] cacheRspData,
  output logic [TAG_W-1:0]  cacheRspTag,
  input  logic              pfReqValid,
  output logic              pfReqReady,
  input  logic              pfReqWrite,
  input  logic [ADDR_W-1:0] pfReqAddr,
  input  logic [TAG_W-1:0]  pfReqTag,
  output logic              pfRspValid,
  input  logic              pfRspReady,
  output logic [DATA_W-1:0] pfRspData,
  output logic [TAG_W-1:0]  pfRspTag,
  output logic              memReqValid,
  input  logic              memReqReady,
  output logic              memReqWrite,
  output logic [ADDR_W-1:0] memReqAddr,
  input  logic              memRspValid,
  output logic              memRspReady,
  input  logic [DATA_W-1:0] memRspData
);
  localparam int ENTRY_W = 1 + TAG_W + ADDR_W;

  strobe_t                 strobe;
  status_t                 status;
  logic [1:0]              reqReady, rspValid;
  logic [1:0][ENTRY_W-1:0] reqEntry;
  logic [TAG_W-1:0]        rspTag;

  assign reqEntry[0] = {cacheReqWrite, cacheReqTag, cacheReqAddr};
  assign reqEntry[1] = {pfReqWrite, pfReqTag, pfReqAddr};

  req_sched_dpath #(
    .ADDR_W(ADDR_W), .TAG_W(TAG_W), .Q_DEPTH(Q_DEPTH), .RCPT_DEPTH(RCPT_DEPTH)
  ) dpath_i (
    .clk         (clk),
    .rstN        (rstN),
    .reqValid    ({pfReqValid, cacheReqValid}),
    .reqReady    (reqReady),
    .reqEntry    (reqEntry),
    .strobe      (strobe),
    .status      (status),
    .memRspValid (memRspValid),
    .memReqWrite (memReqWrite),
    .memReqAddr  (memReqAddr),
    .rspValid    (rspValid),
    .rspTag      (rspTag)
  );

  req_sched_ctrl ctrl_i (
    .clk         (clk),
    .rstN        (rstN),
    .status      (status),
    .memReqReady (memReqReady),
    .memRspValid (memRspValid),
    .rspReady    ({pfRspReady, cacheRspReady}),
    .strobe      (strobe),
    .memReqValid (memReqValid),
    .memRspReady (memRspReady)
  );

  assign cacheReqReady = reqReady[0];
  assign pfReqReady    = reqReady[1];
  assign cacheRspValid = rspValid[0];
  assign pfRspValid    = rspValid[1];
  assign cacheRspTag   = rspTag;
  assign pfRspTag      = rspTag;
  assign cacheRspData  = memRspData;
  assign pfRspData     = memRspData;
endmodule

// File: rtl/req_sched_chk.sv
module req_sched_chk
  import req_sched_pkg::*;
#(
  parameter int ADDR_W     = 16,
  parameter int DATA_W     = 32,
  parameter int TAG_W      = 4,
  parameter int Q_DEPTH    = 4,
  parameter int RCPT_DEPTH = 8
) (
  input logic              clk,
  input logic              rstN,
  input logic              cacheReqValid,
  input logic              cacheReqReady,
  input logic              cacheRspValid,
  input logic              cacheRspReady,
  input logic [DATA_W-1:0] cacheRspData,
  input logic [TAG_W-1:0]  cacheRspTag,
  input logic              pfRspValid,
  input logic              memReqValid,
  input logic              memReqReady,
  input logic              memReqWrite,
  input logic [ADDR_W-1:0] memReqAddr,
  input logic              memRspValid,
  input logic              memRspReady,
  input strobe_t           strobe
);
  localparam int OW = $clog2(RCPT_DEPTH + 1) + 1;
  localparam int QW = $clog2(Q_DEPTH + 1) + 1;

  logic [OW-1:0] inFlight;
  logic [QW-1:0] cacheOcc;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      inFlight <= '0;
      cacheOcc <= '0;
    end else begin
      inFlight <= inFlight + OW'(memReqValid && memReqReady && !memReqWrite)
                           - OW'(memRspValid && memRspReady);
      cacheOcc <= cacheOcc + QW'(cacheReqValid && cacheReqReady) - QW'(strobe.popCache);
    end
  end

  assert_hold_req_R9: assert property (@(posedge clk) disable iff (!rstN)
    memReqValid && !memReqReady |=> memReqValid && $stable(memReqAddr) && $stable(memReqWrite));

  assert_max_inflight_R3: assert property (@(posedge clk) disable iff (!rstN)
    inFlight <= OW'(RCPT_DEPTH));

  assert_read_stall_R3: assert property (@(posedge clk) disable iff (!rstN)
    (inFlight == OW'(RCPT_DEPTH)) && memReqValid |-> memReqWrite);

  assert_queue_full_R7: assert property (@(posedge clk) disable iff (!rstN)
    (cacheOcc == QW'(Q_DEPTH)) == !cacheReqReady);

  assert_one_dest_R5: assert property (@(posedge clk) disable iff (!rstN)
    !(cacheRspValid && pfRspValid));

  assert_rsp_backed_R5: assert property (@(posedge clk) disable iff (!rstN)
    (cacheRspValid || pfRspValid) |-> memRspValid && (inFlight != '0));

  assert_rsp_hold_R6: assert property (@(posedge clk) disable iff (!rstN)
    cacheRspValid && !cacheRspReady |-> !memRspReady);

  assert_rsp_stable_R6: assert property (@(posedge clk) disable iff (!rstN)
    cacheRspValid && !cacheRspReady |=> cacheRspValid && $stable(cacheRspTag) && $stable(cacheRspData));
endmodule

bind req_sched_top req_sched_chk #(
  .ADDR_W(ADDR_W), .DATA_W(DATA_W), .TAG_W(TAG_W), .Q_DEPTH(Q_DEPTH), .RCPT_DEPTH(RCPT_DEPTH)
) chk_i (.*);

// File: tb/req_sched_tb.sv
`timescale 1ns/1ps
module req_sched_top_tb_top;
  localparam int LAT = 100;

  logic clk = 1'b0;
  always #2.5 clk = ~clk;
  logic rstN = 1'b0;

  logic cacheReqValid = 0, cacheReqWrite = 0, cacheRspReady = 0;
  logic [15:0] cacheReqAddr = 0;
  logic [3:0] cacheReqTag = 0;
  logic pfReqValid = 0, pfReqWrite = 0, pfRspReady = 0;
  logic [15:0] pfReqAddr = 0;
  logic [3:0] pfReqTag = 0;
  logic memReqReady = 0, memRspValid = 0;
  logic [31:0] memRspData = 0;
  logic cacheReqReady, cacheRspValid, pfReqReady, pfRspValid;
  logic [31:0] cacheRspData, pfRspData;
  logic [3:0] cacheRspTag, pfRspTag;
  logic memReqValid, memReqWrite, memRspReady;
  logic [15:0] memReqAddr;

  req_sched_top dut_i (.*);

  int total = 0, bad = 0;
  bit done = 0;
  int cyc = 0;
  int memMode = 0, rspMode = 0;
  bit cacheHold = 0;

  // expectations per client (0 cache, 1 prefetch); cache addrs < 0x8000
  logic [15:0] expAddr [2][64];
  logic        expWr   [2][64];
  int expHead [2] = '{0, 0}, expTail [2] = '{0, 0};
  logic [3:0]  rspTagQ  [2][64];
  logic [31:0] rspDataQ [2][64];
  int rspHead [2] = '{0, 0}, rspTail [2] = '{0, 0};
  int rspCount [2] = '{0, 0};
  int outstanding = 0, maxOut = 0;
  int grantLog [16];
  int grantCnt = 0;

  // memory model state
  logic [15:0] mAddr [64];
  int mDue [64];
  int mHead = 0, mTail = 0;

  function automatic logic [31:0] memData(input logic [15:0] a);
    return {a ^ 16'hA5A5, a};
  endfunction

  task automatic chk(input bit ok, input string req, input logic [63:0] act, input logic [63:0] exp);
    total++;
    if (!ok) begin
      bad++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic finishRun();
    if (!done) begin
      done = 1;
      $display("  test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  endtask

  // memory model and ready patterns
  always begin
    bit rf, rw, sf;
    logic [15:0] ra;
    @(negedge clk);
    rf = memReqValid && memReqReady; rw = memReqWrite; ra = memReqAddr;
    sf = memRspValid && memRspReady;
    @(posedge clk); #1;
    cyc++;
    if (rf && !rw) begin mAddr[mTail % 64] = ra; mDue[mTail % 64] = cyc + LAT; mTail++; end
    if (sf) mHead++;
    memRspValid = (mHead != mTail) && (mDue[mHead % 64] <= cyc);
    memRspData  = memData(mAddr[mHead % 64]);
    case (memMode)
      0: memReqReady = 0;
      1: memReqReady = 1;
      2: memReqReady = cyc[0];
      default: memReqReady = (cyc % 3) != 0;
    endcase
    case (rspMode)
      0: begin cacheRspReady = 1; pfRspReady = 1; end
      1: begin cacheRspReady = cyc[0]; pfRspReady = !cyc[0]; end
      default: begin cacheRspReady = cyc[1]; pfRspReady = (cyc % 3) != 0; end
    endcase
    if (cacheHold) cacheRspReady = 0;
  end

  // monitor
  always @(negedge clk) if (rstN) begin
    if (memReqValid && memReqReady) begin
      int c;
      c = memReqAddr[15] ? 1 : 0;
      if (expHead[c] == expTail[c]) chk(0, "R1 unexpected request", memReqAddr, 0);
      else begin
        chk(memReqAddr == expAddr[c][expHead[c] % 64] && memReqWrite == expWr[c][expHead[c] % 64],
            "R1 request order", {memReqWrite, memReqAddr},
            {expWr[c][expHead[c] % 64], expAddr[c][expHead[c] % 64]});
        expHead[c]++;
      end
      if (grantCnt < 16) grantLog[grantCnt] = c;
      grantCnt++;
      if (!memReqWrite) begin
        outstanding++;
        if (outstanding > maxOut) maxOut = outstanding;
        if (outstanding > 8) chk(0, "R3 too many in flight", outstanding, 8);
      end
    end
    if (memRspValid && memRspReady) outstanding--;
    if (cacheRspValid && cacheRspReady) begin
      rspCount[0]++;
      if (rspHead[0] == rspTail[0]) chk(0, "R4 response without read", cacheRspTag, 0);
      else begin
        chk(cacheRspTag == rspTagQ[0][rspHead[0] % 64] && cacheRspData == rspDataQ[0][rspHead[0] % 64],
            "R5 cache response", {cacheRspTag, cacheRspData},
            {rspTagQ[0][rspHead[0] % 64], rspDataQ[0][rspHead[0] % 64]});
        rspHead[0]++;
      end
    end
    if (pfRspValid && pfRspReady) begin
      rspCount[1]++;
      if (rspHead[1] == rspTail[1]) chk(0, "R4 response without read", pfRspTag, 0);
      else begin
        chk(pfRspTag == rspTagQ[1][rspHead[1] % 64] && pfRspData == rspDataQ[1][rspHead[1] % 64],
            "R5 prefetch response", {pfRspTag, pfRspData},
            {rspTagQ[1][rspHead[1] % 64], rspDataQ[1][rspHead[1] % 64]});
        rspHead[1]++;
      end
    end
  end

  task automatic sendReq(input int c, input bit wr, input logic [15:0] addr, input logic [3:0] tag);
    @(posedge clk); #1;
    if (c == 0) begin cacheReqValid = 1; cacheReqWrite = wr; cacheReqAddr = addr; cacheReqTag = tag; end
    else        begin pfReqValid = 1;    pfReqWrite = wr;    pfReqAddr = addr;    pfReqTag = tag;    end
    forever begin
      @(negedge clk);
      if ((c == 0) ? cacheReqReady : pfReqReady) break;
    end
    expAddr[c][expTail[c] % 64] = addr; expWr[c][expTail[c] % 64] = wr; expTail[c]++;
    if (!wr) begin
      rspTagQ[c][rspTail[c] % 64] = tag; rspDataQ[c][rspTail[c] % 64] = memData(addr); rspTail[c]++;
    end
    @(posedge clk); #1;
    if (c == 0) cacheReqValid = 0; else pfReqValid = 0;
  endtask

  task automatic waitIdle();
    int n;
    n = 0;
    while (n < 6000 && !(expHead[0] == expTail[0] && expHead[1] == expTail[1] &&
                         rspHead[0] == rspTail[0] && rspHead[1] == rspTail[1] && outstanding == 0)) begin
      @(negedge clk); n++;
    end
    chk(n < 6000, "R5 all reads answered", n, 0);
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    chk(0, "watchdog", cyc, 0);
    finishRun();
  end

  initial begin
    repeat (3) @(posedge clk);
    #1 rstN = 1;
    @(negedge clk);
    // R8 reset state
    chk(!memReqValid, "R8 memReqValid", memReqValid, 0);
    chk(!cacheRspValid && !pfRspValid, "R8 rsp valid", {cacheRspValid, pfRspValid}, 0);
    chk(cacheReqReady && pfReqReady, "R8 req ready", {cacheReqReady, pfReqReady}, 2'b11);

    // R7: fill both queues with memory blocked
    memMode = 0;
    for (int i = 0; i < 4; i++) sendReq(0, i == 2, 16'h0100 + 16'(i * 16), 4'(i));
    @(negedge clk);
    chk(!cacheReqReady, "R7 cache full", cacheReqReady, 0);
    chk(pfReqReady, "R7 prefetch not full", pfReqReady, 1);
    chk(memReqValid && memReqAddr == 16'h0100, "R9 request held", memReqAddr, 16'h0100);
    for (int i = 0; i < 4; i++) sendReq(1, 0, 16'h8000 + 16'(i * 32), 4'(8 + i));
    @(negedge clk);
    chk(!pfReqReady, "R7 prefetch full", pfReqReady, 0);
    chk(memReqValid && memReqAddr == 16'h0100 && !memReqWrite, "R9 still held", memReqAddr, 16'h0100);

    // R2: release the port, expect strict alternation, cache first
    grantCnt = 0;
    memMode = 1;
    for (int n = 0; n < 100 && grantCnt < 8; n++) @(negedge clk);
    for (int i = 0; i < 8; i++)
      chk(grantLog[i] == (i % 2), "R2 alternation", grantLog[i], i % 2);
    waitIdle();

    // R3: many prefetch reads against the long latency
    maxOut = 0;
    for (int i = 0; i < 12; i++) sendReq(1, 0, 16'h9000 + 16'(i * 64), 4'(i));
    waitIdle();
    chk(maxOut == 8, "R3 in-flight limit reached", maxOut, 8);

    // R6: hold the cache response
    cacheHold = 1;
    sendReq(0, 0, 16'h0300, 4'd5);
    repeat (LAT + 20) @(negedge clk);
    chk(cacheRspValid && cacheRspTag == 4'd5 && cacheRspData == memData(16'h0300),
        "R6 response waiting", {cacheRspValid, cacheRspTag, cacheRspData},
        {1'b1, 4'd5, memData(16'h0300)});
    chk(!memRspReady, "R6 memory held", memRspReady, 0);
    repeat (10) @(negedge clk);
    chk(cacheRspValid && cacheRspData == memData(16'h0300), "R6 still stable", cacheRspData, memData(16'h0300));
    cacheHold = 0;
    waitIdle();

    // R4: writes only, no responses
    begin
      int before0, before1;
      before0 = rspCount[0]; before1 = rspCount[1];
      for (int i = 0; i < 3; i++) sendReq(0, 1, 16'h0500 + 16'(i * 4), 4'(i));
      for (int i = 0; i < 2; i++) sendReq(1, 1, 16'hA000 + 16'(i * 4), 4'(i));
      waitIdle();
      repeat (LAT + 20) @(negedge clk);
      chk(rspCount[0] == before0 && rspCount[1] == before1, "R4 writes silent",
          rspCount[0] + rspCount[1], before0 + before1);
    end

    // sweep of memory and response stall patterns with concurrent traffic
    for (int mm = 1; mm <= 3; mm++) begin
      for (int rm = 0; rm <= 2; rm++) begin
        int combo;
        combo = (mm - 1) * 3 + rm;
        memMode = mm; rspMode = rm;
        fork
          for (int i = 0; i < 10; i++)
            sendReq(0, (i % 4) == 3, 16'h0400 + 16'(combo * 64) + 16'(i * 4), 4'(i));
          for (int i = 0; i < 10; i++)
            sendReq(1, 0, 16'h8000 + 16'(combo * 256) + 16'(i * 32), 4'(i % 4));
        join
        waitIdle();
      end
    end

    finishRun();
  end
endmodule